// File: doc/BRIEF.md
# Secure Seconds Counter with Alarm

This block keeps time as a count of whole seconds plus a fraction of a second. A 15-bit fraction advances once per pulse of a 32.768 kHz tick. When the fraction wraps from 32767 back to 0, the seconds count goes up by one. After a battery reset the counter sits still until software loads a seconds value. Loading a seconds value arms the counter and clears the fraction. From then on the counter runs only while every start condition holds: the enable bit is set, no overflow is pending, the non-valid input is low and the security controller is not freezing it.

Two lock inputs protect the counter. A hard lock and a soft lock both block any change to the seconds or the fraction, but neither one stops counting. An alarm-compare register raises a sticky alarm flag on the step where the seconds count reaches the stored value. An all-ones compare value means no alarm. A wrap of the seconds count past its maximum sets an overflow flag. It also emits a one-cycle overflow event, which the security controller can treat as a tamper source. While the overflow flag is set, the counter is frozen.

Top module: `secure_sec_counter`

## Requirements
- R1: After reset, `seconds` is 0, `frac` is 0, and `alarm_flag`, `alarm_irq`, `ovf_flag` and `ovf_evt` are all 0.
- R2: A counter that has not had a seconds load since reset does not advance, even with `cnt_en` high and `tick` pulsing.
- R3: An accepted seconds write (`wr_sec` with both locks low) sets `seconds` to `wr_data` and `frac` to 0 on the next edge, and arms the counter. Once armed and running, each `tick` adds one to `frac`, and `seconds` goes up by one on the tick that wraps `frac` from 32767 to 0.
- R4: While `cnt_en` is 0, `non_valid` is 1, `freeze` is 1, or `ovf_flag` is 1, ticks change neither `seconds` nor `frac`.
- R5: While `hard_lock` or `soft_lock` is 1, `wr_sec` and `wr_frac` have no effect on `seconds` or `frac`.
- R6: An accepted fraction write (`wr_frac` with both locks low) loads `wr_data[14:0]` into `frac` and leaves `seconds` unchanged.
- R7: On the edge where `seconds` steps up to the value held in the alarm register, `alarm_flag` goes to 1 and stays at 1 until `clr_alarm` is pulsed. `alarm_irq` equals `alarm_flag` AND `alarm_ie`.
- R8: While the alarm register holds all ones (written through `wr_alarm`), `alarm_flag` is never set. This holds even when `seconds` steps up to all ones.
- R9: The alarm is checked only on a seconds step. Loading `seconds` with the alarm value does not set `alarm_flag`.
- R10: A step from all-ones `seconds` gives 0, sets `ovf_flag` and pulses `ovf_evt` for exactly one cycle. The counter stays stopped until `clr_ovf` clears `ovf_flag`.
- R11: A seconds write in the same cycle as a tick takes priority: `seconds` equals the written value and `frac` is 0, with no step applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (battery reset) |
| tick | input | 1 | One-cycle pulse at 32.768 kHz |
| cnt_en | input | 1 | Counter enable |
| hard_lock | input | 1 | Hard write lock for seconds and fraction |
| soft_lock | input | 1 | Soft write lock for seconds and fraction |
| freeze | input | 1 | Stop request from the security controller |
| non_valid | input | 1 | Non-valid state; stops counting |
| wr_sec | input | 1 | Write strobe for seconds |
| wr_frac | input | 1 | Write strobe for fraction |
| wr_alarm | input | 1 | Write strobe for alarm compare value |
| wr_data | input | 32 | Write data shared by all strobes |
| clr_alarm | input | 1 | Write-one-to-clear for the alarm flag |
| clr_ovf | input | 1 | Write-one-to-clear for the overflow flag |
| alarm_ie | input | 1 | Alarm interrupt enable |
| seconds | output | 32 | Current seconds count |
| frac | output | 15 | Current fraction of a second |
| ovf_flag | output | 1 | Sticky seconds-overflow flag |
| ovf_evt | output | 1 | One-cycle overflow event toward the security controller |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The counting path is run under four patterns:
- Unarmed counting separates "enabled" from "armed".
- A run of ticks from a loaded fraction near 32767 shows the fraction carry into the seconds.
- Ticks under each stop condition, applied one at a time, show that every condition gates on its own.
- Writes under each lock separate the lock path from the stop path.

The alarm is approached three ways: by a carry step onto the match value, by a direct load of that value, and with the all-ones unset code. These show that only a step can fire it. The seconds count is then driven from all ones through a wrap to show the overflow event, the freeze that follows it and the recovery after a clear. A final write that collides with a tick checks which update wins.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  // Decoded per-cycle control for the counter datapath.
  typedef struct packed {
    logic ld_sec;   // accepted seconds load
    logic ld_frac;  // accepted fraction load
    logic adv;      // fraction advances this cycle
  } ssc_ctl_t;

  // Loads beat counting. A seconds load beats a fraction load.
  function automatic ssc_ctl_t ssc_decode(input logic wr_sec,
                                          input logic wr_frac,
                                          input logic tick,
                                          input logic run,
                                          input logic unlocked);
    ssc_ctl_t c;
    c.ld_sec  = wr_sec & unlocked;
    c.ld_frac = wr_frac & unlocked & ~c.ld_sec;
    c.adv     = tick & run & ~c.ld_sec & ~c.ld_frac;
    return c;
  endfunction

endpackage

// File: rtl/ssc_prescaler.sv
module ssc_prescaler #(
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [FRAC_W-1:0] load_val,
  input  logic              adv,
  output logic [FRAC_W-1:0] frac_q,
  output logic              carry
);
  localparam logic [FRAC_W-1:0] FRAC_MAX = {FRAC_W{1'b1}};

  assign carry = adv && (frac_q == FRAC_MAX);

  always_ff @(posedge clk) begin
    if (rst)       frac_q <= '0;
    else if (clr)  frac_q <= '0;
    else if (load) frac_q <= load_val;
    else if (adv)  frac_q <= frac_q + FRAC_W'(1);
  end
endmodule

// File: rtl/ssc_seconds.sv
module ssc_seconds #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEC_W-1:0] load_val,
  input  logic             step,
  input  logic             clr_ovf,
  output logic [SEC_W-1:0] sec_q,
  output logic [SEC_W-1:0] sec_inc,
  output logic             ovf_q,
  output logic             ovf_pulse
);
  localparam logic [SEC_W-1:0] SEC_MAX = {SEC_W{1'b1}};

  logic wrap;
  assign sec_inc = sec_q + SEC_W'(1);
  assign wrap    = step && (sec_q == SEC_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q     <= '0;
      ovf_q     <= 1'b0;
      ovf_pulse <= 1'b0;
    end else begin
      if (load)      sec_q <= load_val;
      else if (step) sec_q <= sec_inc;
      if (wrap)         ovf_q <= 1'b1;
      else if (clr_ovf) ovf_q <= 1'b0;
      ovf_pulse <= wrap;
    end
  end
endmodule

// File: rtl/ssc_alarm.sv
module ssc_alarm #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [SEC_W-1:0] wr_val,
  input  logic             step,
  input  logic [SEC_W-1:0] next_sec,
  input  logic             clr,
  output logic [SEC_W-1:0] cmp_q,
  output logic             flag_q
);
  localparam logic [SEC_W-1:0] UNSET = {SEC_W{1'b1}};

  logic hit;
  assign hit = step && (cmp_q != UNSET) && (next_sec == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= UNSET;
      flag_q <= 1'b0;
    end else begin
      if (wr) cmp_q <= wr_val;
      if (hit)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/secure_sec_counter.sv
module secure_sec_counter #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cnt_en,
  input  logic              hard_lock,
  input  logic              soft_lock,
  input  logic              freeze,
  input  logic              non_valid,
  input  logic              wr_sec,
  input  logic              wr_frac,
  input  logic              wr_alarm,
  input  logic [SEC_W-1:0]  wr_data,
  input  logic              clr_alarm,
  input  logic              clr_ovf,
  input  logic              alarm_ie,
  output logic [SEC_W-1:0]  seconds,
  output logic [FRAC_W-1:0] frac,
  output logic              ovf_flag,
  output logic              ovf_evt,
  output logic              alarm_flag,
  output logic              alarm_irq
);
  import ssc_pkg::*;

  logic             armed_q;
  logic             run;
  logic             carry;
  logic [SEC_W-1:0] sec_inc;
  logic [SEC_W-1:0] alarm_q;
  ssc_ctl_t         ctl;

  assign run = armed_q & cnt_en & ~ovf_flag & ~non_valid & ~freeze;
  assign ctl = ssc_decode(wr_sec, wr_frac, tick, run, ~(hard_lock | soft_lock));

  always_ff @(posedge clk) begin
    if (rst)             armed_q <= 1'b0;
    else if (ctl.ld_sec) armed_q <= 1'b1;
  end

  ssc_prescaler #(.FRAC_W(FRAC_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .clr      (ctl.ld_sec),
    .load     (ctl.ld_frac),
    .load_val (wr_data[FRAC_W-1:0]),
    .adv      (ctl.adv),
    .frac_q   (frac),
    .carry    (carry)
  );

  ssc_seconds #(.SEC_W(SEC_W)) u_sec (
    .clk       (clk),
    .rst       (rst),
    .load      (ctl.ld_sec),
    .load_val  (wr_data),
    .step      (carry),
    .clr_ovf   (clr_ovf),
    .sec_q     (seconds),
    .sec_inc   (sec_inc),
    .ovf_q     (ovf_flag),
    .ovf_pulse (ovf_evt)
  );

  ssc_alarm #(.SEC_W(SEC_W)) u_alm (
    .clk      (clk),
    .rst      (rst),
    .wr       (wr_alarm),
    .wr_val   (wr_data),
    .step     (carry),
    .next_sec (sec_inc),
    .clr      (clr_alarm),
    .cmp_q    (alarm_q),
    .flag_q   (alarm_flag)
  );

  assign alarm_irq = alarm_flag & alarm_ie;
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic              hard_lock,
  input logic              soft_lock,
  input logic              freeze,
  input logic              non_valid,
  input logic              wr_sec,
  input logic              wr_frac,
  input logic [SEC_W-1:0]  wr_data,
  input logic [SEC_W-1:0]  seconds,
  input logic [FRAC_W-1:0] frac,
  input logic              ovf_flag,
  input logic              ovf_evt,
  input logic              alarm_flag,
  input logic [SEC_W-1:0]  alarm_q
);
  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_sec && !hard_lock && !soft_lock)
    |=> (seconds == $past(wr_data)) && (frac == '0));

  assert_stopped_R4: assert property (@(posedge clk) disable iff (rst)
    ((!cnt_en || non_valid || freeze || ovf_flag) && !wr_sec && !wr_frac)
    |=> $stable(seconds) && $stable(frac));

  assert_lock_R5: assert property (@(posedge clk) disable iff (rst)
    ((hard_lock || soft_lock) && wr_sec)
    |=> (seconds == $past(seconds)) || (seconds == $past(seconds) + SEC_W'(1)));

  assert_unset_R8: assert property (@(posedge clk) disable iff (rst)
    (&alarm_q) |=> !$rose(alarm_flag));

  assert_step_only_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_flag) |-> (seconds != $past(seconds)));

  assert_ovf_state_R10: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |-> ovf_flag && (seconds == '0));

  assert_ovf_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> !ovf_evt);
endmodule

bind secure_sec_counter ssc_checker #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cnt_en     (cnt_en),
  .hard_lock  (hard_lock),
  .soft_lock  (soft_lock),
  .freeze     (freeze),
  .non_valid  (non_valid),
  .wr_sec     (wr_sec),
  .wr_frac    (wr_frac),
  .wr_data    (wr_data),
  .seconds    (seconds),
  .frac       (frac),
  .ovf_flag   (ovf_flag),
  .ovf_evt    (ovf_evt),
  .alarm_flag (alarm_flag),
  .alarm_q    (alarm_q)
);

// File: tb/tb_secure_sec_counter.sv
module tb_secure_sec_counter;
  localparam int SEC_W  = 32;
  localparam int FRAC_W = 15;
  localparam logic [SEC_W-1:0] ONES = {SEC_W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, cnt_en = 0, hard_lock = 0, soft_lock = 0, freeze = 0, non_valid = 0;
  logic wr_sec = 0, wr_frac = 0, wr_alarm = 0, clr_alarm = 0, clr_ovf = 0, alarm_ie = 0;
  logic [SEC_W-1:0]  wr_data = '0;
  logic [SEC_W-1:0]  seconds;
  logic [FRAC_W-1:0] frac;
  logic ovf_flag, ovf_evt, alarm_flag, alarm_irq;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  secure_sec_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) dut (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic put_sec(input logic [SEC_W-1:0] v);
    wr_sec = 1; wr_data = v; step(); wr_sec = 0;
  endtask
  task automatic put_frac(input logic [SEC_W-1:0] v);
    wr_frac = 1; wr_data = v; step(); wr_frac = 0;
  endtask
  task automatic put_alarm(input logic [SEC_W-1:0] v);
    wr_alarm = 1; wr_data = v; step(); wr_alarm = 0;
  endtask
  task automatic ticks(input int n);
    tick = 1; repeat (n) step(); tick = 0;
  endtask

  task automatic t_reset();
    check("R1", "seconds", seconds, 0);
    check("R1", "frac", 32'(frac), 0);
    check("R1", "flags", {ovf_flag, ovf_evt, alarm_flag, alarm_irq}, 0);
  endtask

  task automatic t_unarmed();
    cnt_en = 1; ticks(100);
    check("R2", "seconds unarmed", seconds, 0);
    check("R2", "frac unarmed", 32'(frac), 0);
  endtask

  task automatic t_load();
    put_sec(100);
    check("R3", "seconds load", seconds, 100);
    check("R3", "frac zeroed", 32'(frac), 0);
    ticks(5);
    check("R3", "frac counts", 32'(frac), 5);
    put_frac(32766);
    check("R6", "frac load", 32'(frac), 32766);
    check("R6", "seconds kept", seconds, 100);
    ticks(2);
    check("R3", "seconds carry", seconds, 101);
    check("R3", "frac wrap", 32'(frac), 0);
    ticks(3);
    put_sec(200);
    check("R3", "frac zeroed on reload", 32'(frac), 0);
    ticks(1);
  endtask

  task automatic t_stop();
    cnt_en = 0; ticks(10);
    check("R4", "cnt_en low", 32'(frac), 1);
    cnt_en = 1; non_valid = 1; ticks(10);
    check("R4", "non_valid", 32'(frac), 1);
    non_valid = 0; freeze = 1; ticks(10);
    check("R4", "freeze", 32'(frac), 1);
    freeze = 0; ticks(1);
    check("R4", "resumes", 32'(frac), 2);
    check("R4", "seconds held", seconds, 200);
  endtask

  task automatic t_lock();
    hard_lock = 1; put_sec(5); put_frac(9);
    check("R5", "hard lock seconds", seconds, 200);
    check("R5", "hard lock frac", 32'(frac), 2);
    hard_lock = 0; soft_lock = 1; put_sec(6); put_frac(11);
    check("R5", "soft lock seconds", seconds, 200);
    check("R5", "soft lock frac", 32'(frac), 2);
    soft_lock = 0;
  endtask

  task automatic t_alarm();
    alarm_ie = 1;
    put_alarm(300); put_sec(299); put_frac(32767);
    check("R7", "flag before", alarm_flag, 0);
    ticks(1);
    check("R7", "seconds at match", seconds, 300);
    check("R7", "flag set", alarm_flag, 1);
    check("R7", "irq", alarm_irq, 1);
    ticks(10);
    check("R7", "flag sticky", alarm_flag, 1);
    clr_alarm = 1; step(); clr_alarm = 0;
    check("R7", "flag cleared", alarm_flag, 0);
    put_sec(300); ticks(4);
    check("R9", "load equal no fire", alarm_flag, 0);
    alarm_ie = 0;
    put_sec(299); put_frac(32767); ticks(1);
    check("R7", "flag set ie off", alarm_flag, 1);
    check("R7", "irq masked", alarm_irq, 0);
    clr_alarm = 1; step(); clr_alarm = 0;
  endtask

  task automatic t_unset_ovf();
    put_alarm(ONES); put_sec(ONES - 1); put_frac(32767); ticks(1);
    check("R8", "seconds at max", seconds, ONES);
    check("R8", "unset no fire", alarm_flag, 0);
    put_frac(32767); ticks(1);
    check("R10", "wrap to zero", seconds, 0);
    check("R10", "ovf flag", ovf_flag, 1);
    check("R10", "ovf event", ovf_evt, 1);
    ticks(1);
    check("R10", "event one cycle", ovf_evt, 0);
    check("R10", "stopped frac", 32'(frac), 0);
    clr_ovf = 1; step(); clr_ovf = 0;
    check("R10", "ovf cleared", ovf_flag, 0);
    ticks(1);
    check("R10", "runs again", 32'(frac), 1);
  endtask

  task automatic t_prio();
    put_frac(32767);
    tick = 1; wr_sec = 1; wr_data = 50; step(); wr_sec = 0; tick = 0;
    check("R11", "write wins seconds", seconds, 50);
    check("R11", "write wins frac", 32'(frac), 0);
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    t_reset();
    t_unarmed();
    t_load();
    t_stop();
    t_lock();
    t_alarm();
    t_unset_ovf();
    t_prio();
    finish_up();
  end
endmodule